// File: doc/BRIEF.md
# Shifter Operand Generator

This combinational unit builds the second operand of a data-processing ALU operation, together with the carry that the shifter produces, from a 32-bit instruction word. It also takes the value of the second source register, the value of the shift-count register and the current carry flag. Register reads and the ALU arithmetic itself are done elsewhere.

Three instruction forms are recognised. The first is a constant: an 8-bit value rotated right by an even amount, so that a small field can reach a wide range of 32-bit values. The second is the register value shifted or rotated by a 5-bit amount held in the instruction. The third is the register value shifted or rotated by the low byte of the shift-count register. An immediate rotate by zero becomes a 33-bit rotate through the carry flag. An immediate logical or arithmetic right shift by zero means a shift by 32.

Top module: `shifter_operand_gen`

## Requirements
- R1: When instr_i[27:25] = 3'b001, operand_o equals the zero-extended constant instr_i[7:0] rotated right by 2 × instr_i[11:8] bit positions (0, 2, ... 30).
- R2: In the constant form, carry_o equals operand_o[31] when instr_i[11:8] is nonzero, and equals c_i when it is zero.
- R3: When instr_i[27:25] = 3'b000, instr_i[4] = 0 and the type field instr_i[6:5] = 2'b00 (left shift), with n = instr_i[11:7]: n = 0 passes rm_i and c_i unchanged, and n > 0 shifts left with zero fill and sets carry_o to rm_i[32-n].
- R4: In the immediate-amount form with type 2'b01 (logical right) or 2'b10 (arithmetic right), n in 1..31 fills with zeros or with copies of rm_i[31] and sets carry_o to rm_i[n-1]; n = 0 acts as a shift by 32, which gives 0 (logical) or all copies of rm_i[31] (arithmetic), with carry_o = rm_i[31].
- R5: In the immediate-amount form with type 2'b11 (rotate right) and n > 0, operand_o is rm_i rotated right by n and carry_o = rm_i[n-1].
- R6: In the immediate-amount form with type 2'b11 and n = 0, operand_o = {c_i, rm_i[31:1]} and carry_o = rm_i[0].
- R7: When instr_i[27:25] = 3'b000 and instr_i[4] = 1, the amount is rs_i[7:0]; rs_i[31:8] and instr_i[7] have no effect; an amount of 0 passes rm_i and c_i unchanged.
- R8: In the register-amount form, a left or logical-right shift by 1..31 behaves as in R3 and R4; by exactly 32 it gives 0 with carry_o = rm_i[0] (left) or rm_i[31] (logical right); by more than 32 it gives 0 with carry_o = 0.
- R9: In the register-amount form, an arithmetic right shift by 32 or more gives all copies of rm_i[31] with carry_o = rm_i[31].
- R10: In the register-amount form, a rotate whose amount is nonzero but has its low five bits zero gives rm_i with carry_o = rm_i[31]; otherwise it rotates by the amount modulo 32 with carry_o = rm_i[(amount mod 32) - 1].
- R11: When instr_i[27:25] is neither 3'b000 nor 3'b001, operand_o is 0 and carry_o equals c_i.
- R12: instr_i[31:28] and instr_i[24:12] have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word holding the class, shift and constant fields |
| rm_i | input | 32 | Value of the register to be shifted |
| rs_i | input | 32 | Value of the register holding the shift count (low byte used) |
| c_i | input | 1 | Current carry flag |
| operand_o | output | 32 | Second ALU operand |
| carry_o | output | 1 | Carry produced by the shifter |

## Verification
The embedded assertions check shape invariants for any input: rotations keep the number of set bits, logical right shifts clear the top bit, arithmetic right shifts keep the sign, left shifts clear bit 0, the 33-bit rotate places the old carry in bit 31, and the decoder never sends a zero amount to a real shift. A zero-rotate constant keeps the carry, and unknown classes give a zero operand. Exact values are shown only by the bench. This covers the carry bit picked at each amount, the boundary amounts 0, 31, 32, 33 and 255, the reinterpretation of immediate zero amounts, and the fields that must have no effect. The bench compares against a model that shifts one position at a time.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int INSTR_W = 32;

  // instruction field positions (decoded by the ALU neighbour as well)
  localparam int CLASS_HI = 27;
  localparam int CLASS_LO = 25;
  localparam int ROT_HI   = 11;
  localparam int ROT_LO   = 8;
  localparam int IMM_HI   = 7;
  localparam int IMM_LO   = 0;
  localparam int SAMT_HI  = 11;
  localparam int SAMT_LO  = 7;
  localparam int STYPE_HI = 6;
  localparam int STYPE_LO = 5;
  localparam int BYREG    = 4;

  localparam int IMM_W  = IMM_HI - IMM_LO + 1;
  localparam int ROT_W  = ROT_HI - ROT_LO + 1;
  localparam int SAMT_W = SAMT_HI - SAMT_LO + 1;
  localparam int CNT_W  = 8;  // bits of the count register used

  localparam logic [2:0] CLASS_REG = 3'b000;
  localparam logic [2:0] CLASS_IMM = 3'b001;

  typedef enum logic [1:0] {
    ST_LSL = 2'b00,
    ST_LSR = 2'b01,
    ST_ASR = 2'b10,
    ST_ROR = 2'b11
  } shift_type_e;

  typedef enum logic [2:0] {
    SK_PASS,
    SK_LSL,
    SK_LSR,
    SK_ASR,
    SK_ROR,
    SK_RRX,
    SK_ZERO
  } shift_kind_e;

  function automatic shift_kind_e kind_of(input shift_type_e t);
    case (t)
      ST_LSL:  return SK_LSL;
      ST_LSR:  return SK_LSR;
      ST_ASR:  return SK_ASR;
      default: return SK_ROR;
    endcase
  endfunction
endpackage

// File: rtl/sop_imm_rot.sv
module sop_imm_rot #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] op_o,
  output logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]   amt;
  logic [DATA_W-1:0] base;

  always_comb begin
    amt  = SH_W'({rot_i, 1'b0});
    base = DATA_W'(imm_i);
    op_o = (base >> amt) | (base << (DATA_W - int'(amt)));
    carry_o = (rot_i != '0) ? op_o[DATA_W-1] : c_i;

    // R1
    imm_ones_chk: assert ($countones(op_o) == $countones(imm_i))
      else $error("rotated constant lost bits");
    // R2
    imm_carry_keep_chk: assert (rot_i != '0 || carry_o == c_i)
      else $error("zero rotate changed carry");
  end
endmodule

// File: rtl/sop_decode.sv
module sop_decode
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = CNT_W
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rs_i,
  output logic               imm_sel_o,
  output shift_kind_e        kind_o,
  output logic [AMT_W-1:0]   amt_o
);
  logic [2:0]        cls;
  shift_type_e       stype;
  logic [SAMT_W-1:0] samt;
  logic [AMT_W-1:0]  ramt;
  logic              unused_fields;

  assign cls   = instr_i[CLASS_HI:CLASS_LO];
  assign stype = shift_type_e'(instr_i[STYPE_HI:STYPE_LO]);
  assign samt  = instr_i[SAMT_HI:SAMT_LO];
  assign ramt  = rs_i[AMT_W-1:0];
  assign unused_fields = ^{instr_i[INSTR_W-1:CLASS_HI+1],
                           instr_i[CLASS_LO-1:ROT_HI+1],
                           rs_i[DATA_W-1:AMT_W]};

  always_comb begin
    imm_sel_o = 1'b0;
    kind_o    = SK_ZERO;
    amt_o     = '0;
    if (cls == CLASS_IMM) begin
      imm_sel_o = 1'b1;
    end else if (cls == CLASS_REG) begin
      if (instr_i[BYREG]) begin
        // bit 7 deliberately not examined
        amt_o  = ramt;
        kind_o = (ramt == '0) ? SK_PASS : kind_of(stype);
      end else if (samt != '0) begin
        amt_o  = AMT_W'(samt);
        kind_o = kind_of(stype);
      end else begin
        // zero immediate amount is reinterpreted per type
        case (stype)
          ST_LSL:  kind_o = SK_PASS;
          ST_ROR:  kind_o = SK_RRX;
          default: begin
            kind_o = kind_of(stype);
            amt_o  = AMT_W'(DATA_W);
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/sop_barrel.sv
module sop_barrel
  import sop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = CNT_W
) (
  input  shift_kind_e       kind_i,
  input  logic [AMT_W-1:0]  amt_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  localparam int SH_W = $clog2(DATA_W);
  localparam logic [AMT_W:0] FULL = (AMT_W+1)'(DATA_W);

  logic [SH_W-1:0]          sh;
  logic                     at_full;
  logic                     past_full;
  logic                     msb;
  logic [DATA_W:0]          l_ext;
  logic [DATA_W:0]          r_ext;
  logic signed [DATA_W:0]   a_ext;
  logic [DATA_W-1:0]        rot;

  assign sh        = amt_i[SH_W-1:0];
  assign at_full   = ({1'b0, amt_i} == FULL);
  assign past_full = ({1'b0, amt_i} > FULL);
  assign msb       = rm_i[DATA_W-1];

  // extra bit on each side catches the last bit shifted out
  assign l_ext = {1'b0, rm_i} << sh;
  assign r_ext = {rm_i, 1'b0} >> sh;
  assign a_ext = $signed({rm_i, 1'b0}) >>> sh;
  assign rot   = (rm_i >> sh) | (rm_i << (DATA_W - int'(sh)));

  always_comb begin
    res_o   = rm_i;
    carry_o = c_i;
    case (kind_i)
      SK_PASS: ;
      SK_LSL: begin
        if (past_full) begin
          res_o = '0; carry_o = 1'b0;
        end else if (at_full) begin
          res_o = '0; carry_o = rm_i[0];
        end else begin
          res_o = l_ext[DATA_W-1:0]; carry_o = l_ext[DATA_W];
        end
      end
      SK_LSR: begin
        if (past_full) begin
          res_o = '0; carry_o = 1'b0;
        end else if (at_full) begin
          res_o = '0; carry_o = msb;
        end else begin
          res_o = r_ext[DATA_W:1]; carry_o = r_ext[0];
        end
      end
      SK_ASR: begin
        if (past_full || at_full) begin
          res_o = {DATA_W{msb}}; carry_o = msb;
        end else begin
          res_o = a_ext[DATA_W:1]; carry_o = a_ext[0];
        end
      end
      SK_ROR: begin
        res_o   = rot;
        carry_o = rot[DATA_W-1];
      end
      SK_RRX: begin
        res_o   = {c_i, rm_i[DATA_W-1:1]};
        carry_o = rm_i[0];
      end
      default: begin
        res_o = '0; carry_o = c_i;
      end
    endcase

    // R7
    amt_nonzero_chk: assert (!(kind_i inside {SK_LSL, SK_LSR, SK_ASR, SK_ROR}) || amt_i != '0)
      else $error("shift issued with zero amount");
    // R3
    lsl_lsb_clear_chk: assert (kind_i != SK_LSL || res_o[0] == 1'b0)
      else $error("left shift left bit 0 set");
    // R4
    lsr_msb_clear_chk: assert (kind_i != SK_LSR || res_o[DATA_W-1] == 1'b0)
      else $error("logical right shift kept top bit");
    // R9
    asr_sign_keep_chk: assert (kind_i != SK_ASR || res_o[DATA_W-1] == msb)
      else $error("arithmetic shift lost sign");
    // R10
    ror_ones_chk: assert (kind_i != SK_ROR || $countones(res_o) == $countones(rm_i))
      else $error("rotate changed bit count");
    // R6
    rrx_carry_in_chk: assert (kind_i != SK_RRX || (res_o[DATA_W-1] == c_i && carry_o == rm_i[0]))
      else $error("extended rotate mismatch");
  end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import sop_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  rm_i,
  input  logic [DATA_W-1:0]  rs_i,
  input  logic               c_i,
  output logic [DATA_W-1:0]  operand_o,
  output logic               carry_o
);
  localparam int AMT_W = CNT_W;

  logic              imm_sel;
  shift_kind_e       kind;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] imm_op;
  logic              imm_carry;
  logic [DATA_W-1:0] sh_op;
  logic              sh_carry;

  sop_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_decode (
    .instr_i   (instr_i),
    .rs_i      (rs_i),
    .imm_sel_o (imm_sel),
    .kind_o    (kind),
    .amt_o     (amt)
  );

  sop_imm_rot #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_imm_rot (
    .imm_i   (instr_i[IMM_HI:IMM_LO]),
    .rot_i   (instr_i[ROT_HI:ROT_LO]),
    .c_i     (c_i),
    .op_o    (imm_op),
    .carry_o (imm_carry)
  );

  sop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_barrel (
    .kind_i  (kind),
    .amt_i   (amt),
    .rm_i    (rm_i),
    .c_i     (c_i),
    .res_o   (sh_op),
    .carry_o (sh_carry)
  );

  always_comb begin
    operand_o = imm_sel ? imm_op : sh_op;
    carry_o   = imm_sel ? imm_carry : sh_carry;

    // R11
    other_class_zero_chk: assert (instr_i[CLASS_HI:CLASS_LO] inside {CLASS_REG, CLASS_IMM}
                                  || (operand_o == '0 && carry_o == c_i))
      else $error("unknown class produced operand");
  end
endmodule

// File: tb/test_shifter_operand_gen.sv
module test_shifter_operand_gen;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr, rm, rs;
  logic        c;
  logic [31:0] operand;
  logic        carry;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  shifter_operand_gen i_shifter_operand_gen (
    .instr_i   (instr),
    .rm_i      (rm),
    .rs_i      (rs),
    .c_i       (c),
    .operand_o (operand),
    .carry_o   (carry)
  );

  // one-position-at-a-time model
  function automatic logic [32:0] model(input logic [31:0] ins, input logic [31:0] a,
                                        input logic [31:0] s, input logic ci);
    logic [31:0] v;
    logic        cy;
    int          n;
    logic [1:0]  ty;
    ty = ins[6:5];
    if (ins[27:25] == 3'b001) begin
      v = {24'b0, ins[7:0]};
      n = 2 * int'(ins[11:8]);
      for (int i = 0; i < n; i++) v = {v[0], v[31:1]};
      cy = (n != 0) ? v[31] : ci;
    end else if (ins[27:25] == 3'b000) begin
      v  = a;
      cy = ci;
      n  = ins[4] ? int'(s[7:0]) : int'(ins[11:7]);
      if (!ins[4] && n == 0) begin
        if (ty == 2'b01 || ty == 2'b10) n = 32;
        else if (ty == 2'b11) return {a[0], ci, a[31:1]};
      end
      for (int i = 0; i < n; i++) begin
        case (ty)
          2'b00: begin cy = v[31]; v = v << 1; end
          2'b01: begin cy = v[0];  v = v >> 1; end
          2'b10: begin cy = v[0];  v = {v[31], v[31:1]}; end
          default: begin cy = v[0]; v = {v[0], v[31:1]}; end
        endcase
      end
    end else begin
      v  = '0;
      cy = ci;
    end
    return {cy, v};
  endfunction

  function automatic string req_of(input logic [31:0] ins, input logic [31:0] s);
    if (ins[27:25] == 3'b001) return "R1/R2";
    if (ins[27:25] != 3'b000) return "R11";
    if (!ins[4]) begin
      case (ins[6:5])
        2'b00:   return "R3";
        2'b11:   return (ins[11:7] == 0) ? "R6" : "R5";
        default: return "R4";
      endcase
    end
    if (s[7:0] == 0) return "R7";
    case (ins[6:5])
      2'b10:   return "R9";
      2'b11:   return "R10";
      default: return "R8";
    endcase
  endfunction

  task automatic run(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] s,
                     input logic ci, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    instr = ins; rm = a; rs = s; c = ci;
    @(negedge clk);
    exp = model(ins, a, s, ci);
    n_checks++;
    if (operand !== exp[31:0] || carry !== exp[32]) begin
      n_fail++;
      $display("FAIL %s instr=%h rm=%h rs=%h c=%0d: got op=%h cy=%0d exp op=%h cy=%0d",
               (tag == "") ? req_of(ins, s) : tag, ins, a, s, ci,
               operand, carry, exp[31:0], exp[32]);
    end
  endtask

  function automatic logic [31:0] reg_ins(input logic [1:0] ty, input bit by_reg,
                                          input logic [4:0] n);
    return {4'hE, 3'b000, 4'h4, 1'b0, 4'h1, 4'h2,
            by_reg ? {4'h3, 1'b0} : n, ty, by_reg, 4'h5};
  endfunction

  initial begin
    logic [31:0] ri, ra, rsv;
    int unsigned pick;
    instr = '0; rm = '0; rs = '0; c = 1'b0;
    void'($urandom(32'd4177));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;

    // reset state: all-zero inputs give zero operand, carry 0
    @(negedge clk);
    n_checks++;
    if (operand !== 32'h0 || carry !== 1'b0) begin
      n_fail++;
      $display("FAIL R3 idle: got op=%h cy=%0d exp op=0 cy=0", operand, carry);
    end

    // R1 R2 constant corners
    run(32'hE3A0_00FF, 32'h0, 32'h0, 1'b1, "R1/R2");
    run(32'hE3A0_01FF, 32'h0, 32'h0, 1'b0, "R1/R2");
    run(32'hE3A0_0F81, 32'h0, 32'h0, 1'b0, "R1/R2");
    run(32'hE3A0_0402, 32'h0, 32'h0, 1'b1, "R1/R2");
    // R3 LSL immediate 0 and 31
    run(reg_ins(2'b00, 0, 5'd0),  32'h8000_0001, 32'h0, 1'b1, "R3");
    run(reg_ins(2'b00, 0, 5'd31), 32'h0000_0003, 32'h0, 1'b0, "R3");
    // R4 LSR/ASR immediate 0 means 32
    run(reg_ins(2'b01, 0, 5'd0), 32'h8000_0000, 32'h0, 1'b0, "R4");
    run(reg_ins(2'b10, 0, 5'd0), 32'h8000_1234, 32'h0, 1'b0, "R4");
    run(reg_ins(2'b10, 0, 5'd4), 32'hF000_0018, 32'h0, 1'b0, "R4");
    // R5 R6
    run(reg_ins(2'b11, 0, 5'd1), 32'h0000_0001, 32'h0, 1'b0, "R5");
    run(reg_ins(2'b11, 0, 5'd0), 32'h0000_0001, 32'h0, 1'b1, "R6");
    run(reg_ins(2'b11, 0, 5'd0), 32'hFFFF_FFFE, 32'h0, 1'b0, "R6");
    // R7 amount 0, upper count bits and bit 7 ignored
    run(reg_ins(2'b00, 1, 5'd0), 32'h1234_5678, 32'hFFFF_FF00, 1'b1, "R7");
    run(reg_ins(2'b01, 1, 5'd0) | 32'h80, 32'h8765_4321, 32'hABCD_0004, 1'b0, "R7");
    // R8 32 and 33
    run(reg_ins(2'b00, 1, 5'd0), 32'h0000_0001, 32'd32, 1'b0, "R8");
    run(reg_ins(2'b00, 1, 5'd0), 32'hFFFF_FFFF, 32'd33, 1'b1, "R8");
    run(reg_ins(2'b01, 1, 5'd0), 32'h8000_0000, 32'd32, 1'b0, "R8");
    run(reg_ins(2'b01, 1, 5'd0), 32'hFFFF_FFFF, 32'd255, 1'b1, "R8");
    // R9
    run(reg_ins(2'b10, 1, 5'd0), 32'h8000_0000, 32'd200, 1'b0, "R9");
    run(reg_ins(2'b10, 1, 5'd0), 32'h7FFF_FFFF, 32'd32, 1'b1, "R9");
    // R10
    run(reg_ins(2'b11, 1, 5'd0), 32'h8000_0001, 32'd64, 1'b0, "R10");
    run(reg_ins(2'b11, 1, 5'd0), 32'h0000_0002, 32'd33, 1'b0, "R10");
    // R11
    run(32'hE5A0_0000 | 32'hFF, 32'hFFFF_FFFF, 32'h1, 1'b1, "R11");
    run(32'hEFFF_FFFF, 32'hFFFF_FFFF, 32'h1, 1'b0, "R11");
    // R12 cond and opcode bits flipped, same expected result
    run(reg_ins(2'b10, 0, 5'd7) ^ 32'hF1FF_F000, 32'h9000_00F0, 32'h0, 1'b1, "R12");
    run(32'h03A0_0A3C ^ 32'hF1FF_F000, 32'h0, 32'h0, 1'b0, "R12");

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      ri  = $urandom;
      ra  = $urandom;
      rsv = $urandom;
      pick = $urandom_range(0, 9);
      if (pick < 5)      ri[27:25] = 3'b000;
      else if (pick < 8) ri[27:25] = 3'b001;
      case ($urandom_range(0, 5))
        0: rsv[7:0] = 8'd0;
        1: rsv[7:0] = 8'd32;
        2: rsv[7:0] = 8'd33;
        3: rsv[7:0] = 8'($urandom_range(0, 31));
        default: ;
      endcase
      if ($urandom_range(0, 4) == 0) ri[11:7] = 5'd0;
      run(ri, ra, rsv, 1'($urandom), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule